// File: doc/BRIEF.md
# Grouped Vector Register File

This block holds thirty-two vector registers of VLEN bits each and serves them to a vector pipeline in two ways. A group port moves a run of 2^p consecutive registers, starting at a base index, as one flat bus of elements. It works one register per clock and pulses a done flag at the end. An element port reads or updates a single element of width 8, 16, 32 or 64 bits, addressed by a flat index across the registers that follow a base. The element port gives its result one cycle after the request. Every register update also raises a pulse that the status logic uses to mark the vector state as modified.

The group port first checks that the group fits in the file and that the base is aligned to the group size. A request that fails either check is reported with an error flag, returns zero data and writes nothing. A negative group exponent selects a single whole register. The element port merges the new element into the target register by read-modify-write, so every other slot of that register is kept.

Top module: `vrf_grouped`

## Requirements
- R1: After reset every register holds zero, and all outputs are zero.
- R2: Element i of a register occupies bits [i*W +: W], where W is the element width, so element 0 is in the least significant bits. On the flat group bus, register base+j occupies bits [j*VLEN +: VLEN].
- R3: A group access with exponent p >= 0 covers registers base to base+2^p-1. At done, grp_elems equals 2^p*VLEN/SEW, with the width code 0,1,2,3 meaning 8,16,32,64 bits.
- R4: A negative exponent on grp_lmul (a two's complement field) acts as p = 0. One register is accessed and the access takes one step.
- R5: A group access whose base is not a multiple of 2^p, or where base+2^p exceeds 32, raises grp_err together with grp_done. That access changes no register and leaves grp_rdata at zero.
- R6: A legal group access samples its request at the start edge, then spends one clock edge per register. grp_done is high in the cycle after the 2^p-th edge, and grp_busy is low at that point. An illegal access shows grp_done in the cycle right after the start edge.
- R7: An element access at flat index k with width W targets register base + k/(VLEN/W), at slot k mod (VLEN/W).
- R8: An element write replaces only the target slot, and all other bits of that register are kept.
- R9: el_done, el_err and el_rdata (the old element value, zero-extended) appear in the cycle after the request. If the target register index is 32 or more, el_err is set, nothing is written and el_rdata is zero.
- R10: dirty_set is high for one cycle after each clock edge that writes a register. A group write therefore yields 2^p such cycles and a successful element write yields one.
- R11: An element request made while grp_busy is high, or in the same cycle as grp_start, is ignored. No el_done follows and no register changes.
- R12: When a group read completes, the grp_rdata slices above the group are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| grp_start | input | 1 | start a group access (taken when idle) |
| grp_we | input | 1 | group access writes when 1, reads when 0 |
| grp_base | input | 5 | first register of the group |
| grp_lmul | input | 3 | signed group exponent p |
| grp_sew | input | 2 | element width code for the count |
| grp_wdata | input | 1024 | flat write data, held until done |
| grp_busy | output | 1 | group engine stepping |
| grp_done | output | 1 | one-cycle completion flag |
| grp_err | output | 1 | illegal group, valid with done |
| grp_rdata | output | 1024 | flat read data |
| grp_elems | output | 8 | element count of the last group |
| el_req | input | 1 | element access request |
| el_we | input | 1 | element write when 1 |
| el_base | input | 5 | base register for the flat index |
| el_idx | input | 7 | flat element index |
| el_eew | input | 2 | element width code |
| el_wdata | input | 64 | element write value (low W bits used) |
| el_done | output | 1 | element access completed |
| el_err | output | 1 | target register out of range |
| el_rdata | output | 64 | element read value |
| dirty_set | output | 1 | a register was written on the previous edge |

## Verification
The group result is due 2^p edges after the start edge. The bench counts falling edges from the start until grp_done appears, compares that count with 2^p, and samples grp_rdata, grp_err and grp_elems in that same cycle. Illegal groups must show done with a count of zero. Element results are sampled at the first falling edge after the request edge. dirty_set is tallied at each falling edge inside the group window, and after an element write it is checked in the same cycle as el_done. All inputs change on falling edges, so every sample is taken half a period away from the edge that produced it.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
   typedef enum logic [1:0] {
      EW_8  = 2'd0,
      EW_16 = 2'd1,
      EW_32 = 2'd2,
      EW_64 = 2'd3
   } ew_e;

   // log2 of the element width in bits
   function automatic int ew_log2(input logic [1:0] code);
      return 3 + int'(code);
   endfunction

   localparam int ELEM_MAX_W = 64;
endpackage

// File: rtl/vrf_regs.sv
module vrf_regs #(
   parameter int NREGS = 32,
   parameter int VLEN  = 128,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [VLEN-1:0] wdata,
   input  logic [AW-1:0]   ra_addr,
   output logic [VLEN-1:0] ra_data,
   input  logic [AW-1:0]   rb_addr,
   output logic [VLEN-1:0] rb_data
);
   logic [VLEN-1:0] mem [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
endmodule

// File: rtl/vrf_group_ctl.sv
module vrf_group_ctl #(
   parameter int NREGS = 32,
   parameter int VLEN  = 128,
   parameter int MAXP  = 3,
   localparam int AW   = $clog2(NREGS),
   localparam int LMW  = $clog2(MAXP + 1) + 1,
   localparam int CNTW = (MAXP > 0) ? MAXP : 1,
   localparam int VLOG = $clog2(VLEN),
   localparam int EW   = $clog2((1 << MAXP) * VLEN / 8) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  we,
   input  logic [AW-1:0]         base,
   input  logic signed [LMW-1:0] lmul,
   input  logic [1:0]            sew,
   output logic                  busy,
   output logic                  done,
   output logic                  err,
   output logic                  step_we,
   output logic [AW-1:0]         step_addr,
   output logic [CNTW-1:0]       step_idx,
   output logic [EW-1:0]         elems
);
   logic [LMW-1:0]  p_eff;
   logic [AW:0]     gsize;
   logic [AW:0]     gmask;
   logic            misaligned, overrun, too_deep, illegal;
   logic [EW-1:0]   elems_c;

   logic            busy_q, done_q, err_q, we_q;
   logic [AW-1:0]   base_q;
   logic [CNTW-1:0] cnt_q, last_q;
   logic [EW-1:0]   elems_q;

   always_comb begin
      p_eff      = lmul[LMW-1] ? '0 : lmul;
      too_deep   = int'(p_eff) > MAXP;
      gsize      = (AW+1)'(1) << p_eff;
      gmask      = gsize - (AW+1)'(1);
      misaligned = (({1'b0, base} & gmask) != '0);
      overrun    = (int'({1'b0, base}) + int'(gsize)) > NREGS;
      illegal    = misaligned | overrun | too_deep;
      elems_c    = EW'((32'(gsize) << VLOG) >> vrf_pkg::ew_log2(sew));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         we_q    <= 1'b0;
         base_q  <= '0;
         cnt_q   <= '0;
         last_q  <= '0;
         elems_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (start && !busy_q) begin
            elems_q <= elems_c;
            if (illegal) begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               we_q   <= we;
               base_q <= base;
               cnt_q  <= '0;
               last_q <= CNTW'(gmask);
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q + CNTW'(1);
            if (cnt_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign err       = err_q;
   assign step_we   = busy_q & we_q;
   assign step_addr = base_q + AW'(cnt_q);
   assign step_idx  = cnt_q;
   assign elems     = elems_q;
endmodule

// File: rtl/vrf_elem_path.sv
module vrf_elem_path #(
   parameter int NREGS = 32,
   parameter int VLEN  = 128,
   parameter int MAXP  = 3,
   localparam int AW   = $clog2(NREGS),
   localparam int VLOG = $clog2(VLEN),
   localparam int IDXW = $clog2((1 << MAXP) * VLEN / 8)
) (
   input  logic [AW-1:0]   base,
   input  logic [IDXW-1:0] idx,
   input  logic [1:0]      eew,
   input  logic [63:0]     wdata,
   input  logic [VLEN-1:0] old_reg,
   output logic [AW-1:0]   tgt_addr,
   output logic            bad,
   output logic [63:0]     rd_elem,
   output logic [VLEN-1:0] new_reg
);
   int              wlog, epr_log, sh;
   logic [IDXW-1:0] offset, slot;
   logic [IDXW:0]   tgt_full;
   logic [63:0]     lowmask;
   logic [VLEN-1:0] mask_v, data_v;

   always_comb begin
      wlog     = vrf_pkg::ew_log2(eew);
      epr_log  = VLOG - wlog;
      offset   = idx >> epr_log;
      slot     = idx & ((IDXW'(1) << epr_log) - IDXW'(1));
      tgt_full = (IDXW+1)'(base) + (IDXW+1)'(offset);
      bad      = int'(tgt_full) >= NREGS;
      tgt_addr = AW'(tgt_full);
      sh       = int'(slot) << wlog;
      lowmask  = (eew == 2'(vrf_pkg::EW_64)) ? '1 : ((64'd1 << (1 << wlog)) - 64'd1);
      mask_v   = VLEN'(lowmask) << sh;
      data_v   = VLEN'(wdata & lowmask) << sh;
      rd_elem  = 64'(old_reg >> sh) & lowmask;
      new_reg  = (old_reg & ~mask_v) | (data_v & mask_v);
   end
endmodule

// File: rtl/vrf_grouped.sv
module vrf_grouped #(
   parameter int NREGS = 32,
   parameter int VLEN  = 128,
   parameter int MAXP  = 3,
   localparam int AW   = $clog2(NREGS),
   localparam int LMW  = $clog2(MAXP + 1) + 1,
   localparam int CNTW = (MAXP > 0) ? MAXP : 1,
   localparam int MAXG = 1 << MAXP,
   localparam int GRPW = MAXG * VLEN,
   localparam int IDXW = $clog2(MAXG * VLEN / 8),
   localparam int EW   = IDXW + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  grp_start,
   input  logic                  grp_we,
   input  logic [AW-1:0]         grp_base,
   input  logic signed [LMW-1:0] grp_lmul,
   input  logic [1:0]            grp_sew,
   input  logic [GRPW-1:0]       grp_wdata,
   output logic                  grp_busy,
   output logic                  grp_done,
   output logic                  grp_err,
   output logic [GRPW-1:0]       grp_rdata,
   output logic [EW-1:0]         grp_elems,
   input  logic                  el_req,
   input  logic                  el_we,
   input  logic [AW-1:0]         el_base,
   input  logic [IDXW-1:0]       el_idx,
   input  logic [1:0]            el_eew,
   input  logic [63:0]           el_wdata,
   output logic                  el_done,
   output logic                  el_err,
   output logic [63:0]           el_rdata,
   output logic                  dirty_set
);
   if (VLEN < vrf_pkg::ELEM_MAX_W || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("VLEN must be a power of two of at least the widest element");
   end
   if (NREGS != (1 << AW)) begin : g_bad_nregs
      $error("NREGS must be a power of two");
   end
   if (MAXP < 0 || (1 << MAXP) > NREGS) begin : g_bad_maxp
      $error("MAXP out of range");
   end

   logic            step_we, el_accept, el_bad, wr_en;
   logic [AW-1:0]   step_addr, el_tgt, waddr;
   logic [CNTW-1:0] step_idx;
   logic [VLEN-1:0] ra_data, rb_data, el_new, wdata;
   logic [63:0]     el_rd;
   logic            el_done_q, el_err_q, dirty_q;
   logic [63:0]     el_rdata_q;

   vrf_group_ctl #(.NREGS(NREGS), .VLEN(VLEN), .MAXP(MAXP)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (grp_start),
      .we        (grp_we),
      .base      (grp_base),
      .lmul      (grp_lmul),
      .sew       (grp_sew),
      .busy      (grp_busy),
      .done      (grp_done),
      .err       (grp_err),
      .step_we   (step_we),
      .step_addr (step_addr),
      .step_idx  (step_idx),
      .elems     (grp_elems)
   );

   vrf_elem_path #(.NREGS(NREGS), .VLEN(VLEN), .MAXP(MAXP)) u_elem (
      .base     (el_base),
      .idx      (el_idx),
      .eew      (el_eew),
      .wdata    (el_wdata),
      .old_reg  (rb_data),
      .tgt_addr (el_tgt),
      .bad      (el_bad),
      .rd_elem  (el_rd),
      .new_reg  (el_new)
   );

   // element port only runs when the group engine is idle
   assign el_accept = el_req & ~grp_busy & ~grp_start;

   always_comb begin
      if (step_we) begin
         wr_en = 1'b1;
         waddr = step_addr;
         wdata = grp_wdata[step_idx * VLEN +: VLEN];
      end else begin
         wr_en = el_accept & el_we & ~el_bad;
         waddr = el_tgt;
         wdata = el_new;
      end
   end

   vrf_regs #(.NREGS(NREGS), .VLEN(VLEN)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (waddr),
      .wdata   (wdata),
      .ra_addr (step_addr),
      .ra_data (ra_data),
      .rb_addr (el_tgt),
      .rb_data (rb_data)
   );

   for (genvar j = 0; j < MAXG; j++) begin : g_slice
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grp_rdata[j*VLEN +: VLEN] <= '0;
         end else if (grp_start && !grp_busy) begin
            grp_rdata[j*VLEN +: VLEN] <= '0;
         end else if (grp_busy && step_idx == CNTW'(j)) begin
            grp_rdata[j*VLEN +: VLEN] <= ra_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         el_done_q  <= 1'b0;
         el_err_q   <= 1'b0;
         el_rdata_q <= '0;
         dirty_q    <= 1'b0;
      end else begin
         el_done_q <= el_accept;
         el_err_q  <= el_accept & el_bad;
         dirty_q   <= wr_en;
         if (el_accept) el_rdata_q <= el_bad ? '0 : el_rd;
      end
   end

   assign el_done   = el_done_q;
   assign el_err    = el_err_q;
   assign el_rdata  = el_rdata_q;
   assign dirty_set = dirty_q;
endmodule

// File: rtl/vrf_grouped_chk.sv
module vrf_grouped_chk #(
   parameter int GRPW = 1024
) (
   input logic            clk,
   input logic            rst_n,
   input logic            grp_start,
   input logic            grp_busy,
   input logic            grp_done,
   input logic            grp_err,
   input logic [GRPW-1:0] grp_rdata,
   input logic            el_req,
   input logic            el_done,
   input logic            el_err,
   input logic            dirty_set
);
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done |-> !grp_busy); // R6
   AST_DONE_AFTER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && !grp_err) |-> $past(grp_busy)); // R6
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_err |-> grp_done); // R5
   AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_err |-> !dirty_set); // R5
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      grp_err |-> (grp_rdata == '0)); // R5
   AST_EL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (el_req && !grp_busy && !grp_start) |=> el_done); // R9
   AST_EL_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      el_err |-> el_done); // R9
   AST_EL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_busy || grp_start) |=> !el_done); // R11
endmodule

bind vrf_grouped vrf_grouped_chk #(.GRPW(GRPW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grp_start (grp_start),
   .grp_busy  (grp_busy),
   .grp_done  (grp_done),
   .grp_err   (grp_err),
   .grp_rdata (grp_rdata),
   .el_req    (el_req),
   .el_done   (el_done),
   .el_err    (el_err),
   .dirty_set (dirty_set)
);

// File: tb/sim_vrf_grouped.sv
module sim_vrf_grouped;
   localparam int CLK_PERIOD = 10;
   localparam int VLEN = 128;
   localparam int GRPW = 8 * VLEN;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              grp_start = 1'b0, grp_we = 1'b0;
   logic [4:0]        grp_base = '0;
   logic signed [2:0] grp_lmul = '0;
   logic [1:0]        grp_sew = '0;
   logic [GRPW-1:0]   grp_wdata = '0;
   logic              grp_busy, grp_done, grp_err;
   logic [GRPW-1:0]   grp_rdata;
   logic [7:0]        grp_elems;
   logic              el_req = 1'b0, el_we = 1'b0;
   logic [4:0]        el_base = '0;
   logic [6:0]        el_idx = '0;
   logic [1:0]        el_eew = '0;
   logic [63:0]       el_wdata = '0;
   logic              el_done, el_err, dirty_set;
   logic [63:0]       el_rdata;

   int total = 0;
   int bad = 0;
   logic [VLEN-1:0] shadow [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   vrf_grouped u0 (.*);

   task automatic check(input string req, input logic [GRPW-1:0] act, input logic [GRPW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [GRPW-1:0] model_group(input int base, input int p);
      logic [GRPW-1:0] r = '0;
      for (int j = 0; j < (1 << p); j++) r[j*VLEN +: VLEN] = shadow[base + j];
      return r;
   endfunction

   function automatic logic [GRPW-1:0] pattern(input int seed);
      logic [GRPW-1:0] r;
      for (int w = 0; w < GRPW/32; w++) r[w*32 +: 32] = 32'h9E3779B9 * (w + 1) + 32'(seed);
      return r;
   endfunction

   task automatic run_grp(input logic we, input int base, input int lmul, input int sew,
                          input logic [GRPW-1:0] wd, output logic [GRPW-1:0] rd,
                          output logic er, output int elems, output int cyc, output int dirt);
      @(negedge clk);
      grp_start = 1'b1; grp_we = we; grp_base = base[4:0];
      grp_lmul = lmul[2:0]; grp_sew = sew[1:0]; grp_wdata = wd;
      @(negedge clk);
      grp_start = 1'b0;
      cyc = 0; dirt = 0;
      while (!grp_done && cyc < 40) begin
         @(negedge clk);
         cyc++;
         if (dirty_set) dirt++;
      end
      rd = grp_rdata; er = grp_err; elems = int'(grp_elems);
      grp_we = 1'b0;
   endtask

   task automatic run_el(input logic we, input int base, input int idx, input int eew,
                         input logic [63:0] wd, output logic [63:0] rd, output logic er,
                         output logic dn, output logic dt);
      @(negedge clk);
      el_req = 1'b1; el_we = we; el_base = base[4:0]; el_idx = idx[6:0];
      el_eew = eew[1:0]; el_wdata = wd;
      @(negedge clk);
      el_req = 1'b0; el_we = 1'b0;
      rd = el_rdata; er = el_err; dn = el_done; dt = dirty_set;
   endtask

   function automatic logic [63:0] model_el(input int base, input int idx, input int eew);
      int w = 8 << eew;
      int epr = VLEN / w;
      logic [VLEN-1:0] r = shadow[base + idx / epr];
      logic [63:0] m = (eew == 3) ? '1 : ((64'd1 << w) - 64'd1);
      return 64'(r >> ((idx % epr) * w)) & m;
   endfunction

   task automatic model_el_write(input int base, input int idx, input int eew, input logic [63:0] wd);
      int w = 8 << eew;
      int epr = VLEN / w;
      int t = base + idx / epr;
      for (int b = 0; b < w; b++) shadow[t][(idx % epr) * w + b] = wd[b];
   endtask

   task automatic t_reset;
      logic [GRPW-1:0] rd; logic er; int el, cy, dt;
      check("R1 busy", GRPW'(grp_busy), '0);
      check("R1 done", GRPW'(grp_done), '0);
      check("R1 el_rdata", GRPW'(el_rdata), '0);
      check("R1 dirty", GRPW'(dirty_set), '0);
      for (int b = 0; b < 32; b += 8) begin
         run_grp(1'b0, b, 3, 0, '0, rd, er, el, cy, dt);
         check("R1 regs zero", rd, '0);
      end
   endtask

   task automatic t_group_write_read(input int base, input int p, input int sew, input int seed);
      logic [GRPW-1:0] rd, wd; logic er; int el, cy, dt;
      wd = pattern(seed);
      for (int j = (1 << p); j < 8; j++) wd[j*VLEN +: VLEN] = '0;
      run_grp(1'b1, base, p, sew, wd, rd, er, el, cy, dt);
      for (int j = 0; j < (1 << p); j++) shadow[base + j] = wd[j*VLEN +: VLEN];
      check("R6 write steps", GRPW'(cy), GRPW'(1 << p));
      check("R10 dirty count", GRPW'(dt), GRPW'(1 << p));
      check("R5 no err", GRPW'(er), '0);
      run_grp(1'b0, base, p, sew, '0, rd, er, el, cy, dt);
      check("R2 R12 group read", rd, model_group(base, p));
      check("R3 elems", GRPW'(el), GRPW'((1 << p) * VLEN / (8 << sew)));
      check("R6 read steps", GRPW'(cy), GRPW'(1 << p));
      check("R10 no dirty on read", GRPW'(dt), '0);
   endtask

   task automatic t_fractional;
      logic [GRPW-1:0] rd, wd; logic er; int el, cy, dt;
      wd = pattern(77);
      run_grp(1'b1, 3, -2, 1, wd, rd, er, el, cy, dt);
      shadow[3] = wd[VLEN-1:0];
      check("R4 one step", GRPW'(cy), GRPW'(1));
      check("R4 neighbour kept", shadow[4], model_group(4, 0)[VLEN-1:0]);
      run_grp(1'b0, 3, -1, 1, '0, rd, er, el, cy, dt);
      check("R4 R12 read one reg", rd, GRPW'(shadow[3]));
      check("R4 elems", GRPW'(el), GRPW'(VLEN / 16));
      run_grp(1'b0, 4, 0, 0, '0, rd, er, el, cy, dt);
      check("R4 reg4 untouched", rd, model_group(4, 0));
   endtask

   task automatic t_illegal(input int base, input int p);
      logic [GRPW-1:0] rd; logic er; int el, cy, dt;
      run_grp(1'b1, base, p, 2, pattern(5), rd, er, el, cy, dt);
      check("R5 err", GRPW'(er), GRPW'(1));
      check("R6 illegal done at once", GRPW'(cy), '0);
      check("R5 zero rdata", rd, '0);
      check("R5 no dirty", GRPW'(dirty_set), '0);
      run_grp(1'b0, base & ~((1 << p) - 1), p, 0, '0, rd, er, el, cy, dt);
      check("R5 regs unchanged", rd, model_group(base & ~((1 << p) - 1), p));
   endtask

   task automatic t_elem_read(input int base, input int idx, input int eew);
      logic [63:0] rd; logic er, dn, dt;
      run_el(1'b0, base, idx, eew, '0, rd, er, dn, dt);
      check("R9 el_done", GRPW'(dn), GRPW'(1));
      check("R7 R2 element read", GRPW'(rd), GRPW'(model_el(base, idx, eew)));
   endtask

   task automatic t_elem_write(input int base, input int idx, input int eew, input logic [63:0] wd);
      logic [63:0] rd; logic er, dn, dt;
      logic [GRPW-1:0] grd; logic ger; int el, cy, gdt;
      int t = base + idx / (VLEN / (8 << eew));
      run_el(1'b1, base, idx, eew, wd, rd, er, dn, dt);
      model_el_write(base, idx, eew, wd);
      check("R10 element dirty", GRPW'(dt), GRPW'(1));
      check("R9 no el_err", GRPW'(er), '0);
      run_grp(1'b0, t, 0, 0, '0, grd, ger, el, cy, gdt);
      check("R8 merged register", grd, GRPW'(shadow[t]));
   endtask

   task automatic t_elem_range;
      logic [63:0] rd; logic er, dn, dt;
      run_el(1'b1, 30, 40, 0, 64'hAB, rd, er, dn, dt);
      check("R9 el_err", GRPW'(er), GRPW'(1));
      check("R9 err rdata zero", GRPW'(rd), '0);
      check("R9 err no dirty", GRPW'(dt), '0);
   endtask

   task automatic t_elem_while_busy;
      logic [GRPW-1:0] rd; logic er; int el, cy, dt;
      @(negedge clk);
      grp_start = 1'b1; grp_we = 1'b0; grp_base = 5'd0; grp_lmul = 3'sd3; grp_sew = 2'd3;
      el_req = 1'b1; el_we = 1'b1; el_base = 5'd0; el_idx = 7'd0; el_eew = 2'd3; el_wdata = '1;
      @(negedge clk);
      grp_start = 1'b0;
      @(negedge clk);
      check("R11 no done at start", GRPW'(el_done), '0);
      el_req = 1'b0; el_we = 1'b0;
      @(negedge clk);
      check("R11 no done while busy", GRPW'(el_done), '0);
      while (!grp_done) @(negedge clk);
      check("R11 group read intact", grp_rdata, model_group(0, 3));
      run_grp(1'b0, 0, 0, 0, '0, rd, er, el, cy, dt);
      check("R11 reg0 unchanged", rd, GRPW'(shadow[0]));
   endtask

   initial begin
      for (int i = 0; i < 32; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_group_write_read(4, 2, 2, 11);
      t_group_write_read(8, 3, 0, 23);
      t_group_write_read(16, 1, 3, 31);
      t_fractional();
      t_illegal(5, 1);
      t_illegal(12, 3);
      t_illegal(26, 2);
      t_elem_read(4, 5, 2);
      t_elem_read(8, 37, 0);
      t_elem_read(16, 3, 3);
      t_elem_read(8, 100, 1);
      t_elem_write(8, 21, 0, 64'hFFFF_FFFF_FFFF_FF5A);
      t_elem_write(4, 9, 2, 64'h1234_5678_DEAD_BEEF);
      t_elem_write(16, 2, 3, 64'h0123_4567_89AB_CDEF);
      t_elem_range();
      t_elem_while_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R6 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule